// File: doc/BRIEF.md
# Configuration Context Cache Controller

This block keeps track of which function configurations currently occupy the context slots of a reconfigurable functional unit attached to a processor. The processor names the operation it wants by a small numeric function identifier. The controller looks that identifier up among its slots. If the function is already resident, the controller reports the slot one cycle later and no reload takes place, so switching between resident functions is cheap.

When the function is not resident, the controller picks a slot to overwrite. It uses an empty slot if one exists, and otherwise the slot that was referenced longest ago. It then raises a level request to an external configuration loader, carrying the identifier and the chosen slot. Until the loader signals completion, the controller shows itself busy and turns away further requests. Identifiers outside the loadable range produce a one-cycle error pulse and nothing else.

The bitstream contents and the loader itself lie outside this block. The block only does the bookkeeping, the replacement choice and the handshake.

Top module: `ctx_cache_ctrl`

## Requirements
- R1: While reset is held and afterwards until the first request, `busy`, `ready`, `errPulse` and `loadReq` are low. All slots start empty, so the first request for any valid identifier is a miss.
- R2: A request accepted while idle whose identifier is resident gives, on the next cycle, `ready` high for exactly one cycle with `readySlot` equal to the slot holding it. `loadReq` and `busy` stay low.
- R3: An accepted request for a valid identifier that is not resident raises `busy` and `loadReq` on the next cycle. `loadFuncId` carries the identifier and `loadSlot` carries the chosen slot. All three stay unchanged until the cycle after `loadDone` is sampled high.
- R4: When `loadDone` is sampled high while busy, the next cycle has `busy` and `loadReq` low and `ready` high for one cycle with `readySlot` equal to the loaded slot. The function is resident from then on.
- R5: While `busy` is high, `reqValid` is ignored. It produces no `ready`, no `errPulse`, no change to the load outputs and no change to residency or recency.
- R6: On a miss with at least one empty slot, the victim is the lowest-numbered empty slot.
- R7: On a miss with all slots full, the victim is the slot whose last reference is oldest. A reference is either a hit or a completed load into that slot.
- R8: An accepted request with identifier 14 or greater (4-bit identifier, 14 loadable functions 0 to 13) gives `errPulse` high for one cycle on the next cycle. It gives no `ready` and no load, and leaves residency and recency untouched.
- R9: `loadDone` sampled while not busy has no effect.
- R10: Up to 4 functions are resident at once. Each of them hits repeatedly without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor presents a function request this cycle |
| reqFuncId | input | 4 | Requested function identifier |
| loadDone | input | 1 | Loader reports the requested configuration is in place |
| busy | output | 1 | A reload is outstanding; requests are refused |
| ready | output | 1 | One-cycle pulse: requested function is active |
| readySlot | output | 2 | Slot index of the active function, valid with `ready` |
| errPulse | output | 1 | One-cycle pulse: identifier out of range |
| loadReq | output | 1 | Level request to the loader |
| loadFuncId | output | 4 | Identifier to load, valid with `loadReq` |
| loadSlot | output | 2 | Slot to load into, valid with `loadReq` |

## Verification
A corrupted tag or valid bit shows at the ports the next time that identifier is requested. It appears as a `ready` where a `loadReq` belonged, or the reverse, one cycle after the request. A wrong recency order stays hidden until all four slots are full. It then shows as a wrong `loadSlot` on the first miss that follows. For that reason the bench compares every output on every cycle against a timestamp-based model and drives long random request streams once the slots are full.

// File: rtl/ctx_cache_pkg.sv
package ctx_cache_pkg;

  // strobes from the sequencer to the tag store
  typedef struct packed {
    logic touch;    // hit: refresh recency of wrSlot
    logic install;  // load finished: write tag into wrSlot and refresh
  } ctxStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_LOAD = 1'b1
  } ctxState_e;

endpackage

// File: rtl/ctx_lru_rank.sv
module ctx_lru_rank #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              touchEn,
  input  logic [SLOT_W-1:0] touchSlot,
  output logic [SLOT_W-1:0] lruSlot
);

  localparam logic [SLOT_W-1:0] OLDEST = SLOT_W'(NUM_SLOTS - 1);

  // rank 0 = most recent, NUM_SLOTS-1 = least recent; ranks form a permutation
  logic [SLOT_W-1:0] rank [NUM_SLOTS];
  logic [SLOT_W-1:0] touchedRank;

  assign touchedRank = rank[touchSlot];

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rank[gi] <= SLOT_W'(gi);
      end else if (touchEn) begin
        if (touchSlot == SLOT_W'(gi)) begin
          rank[gi] <= '0;
        end else if (rank[gi] < touchedRank) begin
          rank[gi] <= rank[gi] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    lruSlot = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rank[i] == OLDEST) lruSlot = SLOT_W'(i);
    end
  end

endmodule

// File: rtl/ctx_tag_store.sv
module ctx_tag_store
  import ctx_cache_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctxStrobe_t        strobe,
  input  logic [ID_W-1:0]   lookupId,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [ID_W-1:0]   wrId,
  output logic              hit,
  output logic [SLOT_W-1:0] hitSlot,
  output logic [SLOT_W-1:0] victimSlot
);

  logic [NUM_SLOTS-1:0] slotValid;
  logic [ID_W-1:0]      slotTag [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] matchVec;
  logic [SLOT_W-1:0]    lruSlot;
  logic [SLOT_W-1:0]    freeSlot;
  logic                 anyFree;

  for (genvar gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[gs] <= 1'b0;
        slotTag[gs]   <= '0;
      end else if (strobe.install && wrSlot == SLOT_W'(gs)) begin
        slotValid[gs] <= 1'b1;
        slotTag[gs]   <= wrId;
      end
    end
    assign matchVec[gs] = slotValid[gs] && (slotTag[gs] == lookupId);
  end

  // tags are unique, so at most one match; encode it
  always_comb begin
    hitSlot = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (matchVec[i]) hitSlot = SLOT_W'(i);
    end
  end
  assign hit = |matchVec;

  // lowest-numbered empty slot
  always_comb begin
    freeSlot = '0;
    anyFree  = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!slotValid[i]) begin
        freeSlot = SLOT_W'(i);
        anyFree  = 1'b1;
      end
    end
  end

  ctx_lru_rank #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W)
  ) u_rank (
    .clk      (clk),
    .rstN     (rstN),
    .touchEn  (strobe.touch | strobe.install),
    .touchSlot(wrSlot),
    .lruSlot  (lruSlot)
  );

  assign victimSlot = anyFree ? freeSlot : lruSlot;

endmodule

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_cache_pkg::*;
#(
  parameter int NUM_FUNCS = 14,
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqFuncId,
  input  logic              loadDone,
  input  logic              hit,
  input  logic [SLOT_W-1:0] hitSlot,
  input  logic [SLOT_W-1:0] victimSlot,
  output ctxStrobe_t        strobe,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [ID_W-1:0]   wrId,
  output logic              busy,
  output logic              ready,
  output logic [SLOT_W-1:0] readySlot,
  output logic              errPulse,
  output logic              loadReq,
  output logic [ID_W-1:0]   loadFuncId,
  output logic [SLOT_W-1:0] loadSlot
);

  localparam logic [ID_W:0] FUNC_LIMIT = (ID_W + 1)'(NUM_FUNCS);

  ctxState_e         state;
  logic [ID_W-1:0]   pendId;
  logic [SLOT_W-1:0] pendSlot;
  logic              accept;
  logic              idOk;
  logic              startLoad;
  logic              finish;

  assign accept    = (state == ST_IDLE) && reqValid;
  assign idOk      = {1'b0, reqFuncId} < FUNC_LIMIT;
  assign startLoad = accept && idOk && !hit;
  assign finish    = (state == ST_LOAD) && loadDone;

  always_comb begin
    strobe.touch   = accept && idOk && hit;
    strobe.install = finish;
    wrSlot         = finish ? pendSlot : hitSlot;
    wrId           = pendId;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendId    <= '0;
      pendSlot  <= '0;
      ready     <= 1'b0;
      readySlot <= '0;
      errPulse  <= 1'b0;
    end else begin
      ready    <= strobe.touch || finish;
      errPulse <= accept && !idOk;
      if (strobe.touch) readySlot <= hitSlot;
      else if (finish)  readySlot <= pendSlot;
      unique case (state)
        ST_IDLE: if (startLoad) begin
          state    <= ST_LOAD;
          pendId   <= reqFuncId;
          pendSlot <= victimSlot;
        end
        ST_LOAD: if (loadDone) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state == ST_LOAD);
  assign loadReq    = busy;
  assign loadFuncId = pendId;
  assign loadSlot   = pendSlot;

endmodule

// File: rtl/ctx_cache_ctrl.sv
module ctx_cache_ctrl
  import ctx_cache_pkg::*;
#(
  parameter int NUM_FUNCS = 14,
  parameter int NUM_SLOTS = 4,
  parameter int ID_W      = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqFuncId,
  input  logic              loadDone,
  output logic              busy,
  output logic              ready,
  output logic [SLOT_W-1:0] readySlot,
  output logic              errPulse,
  output logic              loadReq,
  output logic [ID_W-1:0]   loadFuncId,
  output logic [SLOT_W-1:0] loadSlot
);

  ctxStrobe_t        strobe;
  logic [SLOT_W-1:0] wrSlot;
  logic [ID_W-1:0]   wrId;
  logic              hit;
  logic [SLOT_W-1:0] hitSlot;
  logic [SLOT_W-1:0] victimSlot;

  ctx_seq_ctrl #(
    .NUM_FUNCS(NUM_FUNCS),
    .NUM_SLOTS(NUM_SLOTS),
    .ID_W     (ID_W),
    .SLOT_W   (SLOT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqFuncId (reqFuncId),
    .loadDone  (loadDone),
    .hit       (hit),
    .hitSlot   (hitSlot),
    .victimSlot(victimSlot),
    .strobe    (strobe),
    .wrSlot    (wrSlot),
    .wrId      (wrId),
    .busy      (busy),
    .ready     (ready),
    .readySlot (readySlot),
    .errPulse  (errPulse),
    .loadReq   (loadReq),
    .loadFuncId(loadFuncId),
    .loadSlot  (loadSlot)
  );

  ctx_tag_store #(
    .NUM_SLOTS(NUM_SLOTS),
    .ID_W     (ID_W),
    .SLOT_W   (SLOT_W)
  ) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lookupId  (reqFuncId),
    .wrSlot    (wrSlot),
    .wrId      (wrId),
    .hit       (hit),
    .hitSlot   (hitSlot),
    .victimSlot(victimSlot)
  );

endmodule

// File: rtl/ctx_cache_ctrl_chk.sv
module ctx_cache_ctrl_chk #(
  parameter int NUM_FUNCS = 14,
  parameter int ID_W      = 4,
  parameter int SLOT_W    = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ID_W-1:0]   reqFuncId,
  input logic              loadDone,
  input logic              busy,
  input logic              ready,
  input logic [SLOT_W-1:0] readySlot,
  input logic              errPulse,
  input logic              loadReq,
  input logic [ID_W-1:0]   loadFuncId,
  input logic [SLOT_W-1:0] loadSlot
);

  localparam logic [ID_W:0] FUNC_LIMIT = (ID_W + 1)'(NUM_FUNCS);

  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !loadDone) |=> busy);  // R3

  AST_LOAD_ARGS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !loadDone) |=> ($stable(loadFuncId) && $stable(loadSlot) && loadReq));  // R3

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && loadDone) |=> (ready && !busy && !loadReq && readySlot == $past(loadSlot)));  // R4

  AST_REFUSED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !loadDone) |=> (!ready && !errPulse));  // R5

  AST_BAD_ID_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && {1'b0, reqFuncId} >= FUNC_LIMIT) |=> (errPulse && !ready && !busy));  // R8

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqValid && loadDone) |=> (!ready && !busy && !errPulse));  // R9

  AST_MISS_LOAD_ID: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadReq) |-> (loadFuncId == $past(reqFuncId) && $past(reqValid)));  // R3

  AST_READY_EXCL_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !(ready && errPulse) && !(ready && busy));  // R2

endmodule

bind ctx_cache_ctrl ctx_cache_ctrl_chk #(
  .NUM_FUNCS(NUM_FUNCS),
  .ID_W     (ID_W),
  .SLOT_W   (SLOT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqFuncId (reqFuncId),
  .loadDone  (loadDone),
  .busy      (busy),
  .ready     (ready),
  .readySlot (readySlot),
  .errPulse  (errPulse),
  .loadReq   (loadReq),
  .loadFuncId(loadFuncId),
  .loadSlot  (loadSlot)
);

// File: tb/ctx_cache_ctrl_test.sv
module ctx_cache_ctrl_test;

  localparam int NF = 14;
  localparam int NS = 4;
  localparam int IW = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [IW-1:0] reqFuncId = '0;
  logic          loadDone = 1'b0;
  logic          busy, ready, errPulse, loadReq;
  logic [SW-1:0] readySlot, loadSlot;
  logic [IW-1:0] loadFuncId;

  always #2 clk = ~clk;

  ctx_cache_ctrl #(.NUM_FUNCS(NF), .NUM_SLOTS(NS), .ID_W(IW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFuncId(reqFuncId),
    .loadDone(loadDone), .busy(busy), .ready(ready), .readySlot(readySlot),
    .errPulse(errPulse), .loadReq(loadReq), .loadFuncId(loadFuncId),
    .loadSlot(loadSlot)
  );

  int    vecCount = 0;
  int    missCount = 0;
  string curReq = "R1";

  // behavioural model: residency by timestamp of last reference
  int mTag [NS];
  bit mValid [NS];
  int mUse [NS];
  int stamp = 0;
  bit mBusy = 0;
  int mPendId = 0;
  int mPendSlot = 0;
  bit eReady = 0;
  bit eErr = 0;
  int eSlot = 0;

  task automatic checkVal(string what, int act, int exp);
    vecCount++;
    if (act != exp) begin
      missCount++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    checkVal("busy", int'(busy), int'(mBusy));
    checkVal("loadReq", int'(loadReq), int'(mBusy));
    checkVal("ready", int'(ready), int'(eReady));
    checkVal("errPulse", int'(errPulse), int'(eErr));
    if (eReady) checkVal("readySlot", int'(readySlot), eSlot);
    if (mBusy) begin
      checkVal("loadFuncId", int'(loadFuncId), mPendId);
      checkVal("loadSlot", int'(loadSlot), mPendSlot);
    end
  endtask

  task automatic modelStep(bit v, int id, bit d);
    eReady = 0;
    eErr   = 0;
    if (mBusy) begin
      if (d) begin
        mTag[mPendSlot]   = mPendId;
        mValid[mPendSlot] = 1;
        stamp++;
        mUse[mPendSlot]   = stamp;
        mBusy  = 0;
        eReady = 1;
        eSlot  = mPendSlot;
      end
    end else if (v) begin
      if (id >= NF) begin
        eErr = 1;
      end else begin
        int h = -1;
        for (int i = 0; i < NS; i++) if (mValid[i] && mTag[i] == id) h = i;
        if (h >= 0) begin
          stamp++;
          mUse[h] = stamp;
          eReady  = 1;
          eSlot   = h;
        end else begin
          int vic = -1;
          for (int i = NS - 1; i >= 0; i--) if (!mValid[i]) vic = i;
          if (vic < 0) begin
            vic = 0;
            for (int i = 1; i < NS; i++) if (mUse[i] < mUse[vic]) vic = i;
          end
          mBusy     = 1;
          mPendId   = id;
          mPendSlot = vic;
        end
      end
    end
  endtask

  task automatic cyc(bit v, int id, bit d);
    reqValid  = v;
    reqFuncId = IW'(id);
    loadDone  = d;
    modelStep(v, id, d);
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic loadFn(int id, int lat);
    cyc(1, id, 0);
    for (int k = 0; k < lat; k++) cyc(0, 0, 0);
    cyc(0, 0, 1);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      mTag[i] = 0; mValid[i] = 0; mUse[i] = 0;
    end
    repeat (3) @(negedge clk);
    curReq = "R1";
    compareAll();                 // outputs quiet in reset
    rstN = 1'b1;
    cyc(0, 0, 0);
    // first request misses into slot 0
    cyc(1, 3, 0);
    curReq = "R3";
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    curReq = "R5";
    cyc(1, 5, 0);                 // refused while busy
    cyc(1, 15, 0);                // no error while busy
    curReq = "R4";
    cyc(0, 0, 1);
    cyc(0, 0, 0);
    curReq = "R9";
    cyc(0, 0, 1);
    cyc(0, 0, 0);
    curReq = "R2";
    cyc(1, 3, 0);
    cyc(1, 3, 0);                 // back-to-back hit
    curReq = "R6";
    loadFn(5, 1);
    loadFn(7, 0);
    loadFn(9, 3);
    curReq = "R10";
    cyc(1, 3, 0); cyc(1, 5, 0); cyc(1, 7, 0); cyc(1, 9, 0);
    curReq = "R8";
    cyc(1, 14, 0);
    cyc(1, 15, 0);
    cyc(0, 0, 0);
    curReq = "R7";
    cyc(1, 9, 0); cyc(1, 3, 0); cyc(1, 7, 0); cyc(1, 5, 0);
    cyc(1, 15, 0);                // must not refresh anything
    loadFn(0, 2);                 // evicts 9 in slot 3
    loadFn(9, 1);                 // evicts 3 in slot 0
    // random stream with a loader of random latency
    for (int n = 0; n < 3000; n++) begin
      bit v = ($urandom % 4) != 0;
      int id = $urandom % 16;
      bit d = ($urandom % 3) == 0;
      cyc(v, id, d);
    end
    cyc(0, 0, 1);
    cyc(0, 0, 0);
    finishRun();
  end

endmodule